// File: doc/BRIEF.md
# Ternary-Key Content Addressable Memory

A small associative store of four words, each four bits wide. Software-style access works as with an ordinary static RAM: an address picks one word, which is either overwritten or returned on the read data output one cycle later. The store can also run a search. The search presents a key to every word at once and reports, one flag per word, which valid stored words equal that key.

Each key bit has a mask bit beside it. A set mask bit turns that key bit into a don't-care, so that bit never causes a mismatch. A miss output is the NOR of the match flags. It is high exactly when no word matched.

A search never shares a cycle with an access. If a read or write is requested in the same cycle, the search is dropped and the previous results stay. A typical user wires the match vector straight into the word selects of a second memory that holds associated data, as an address translation buffer does.

Top module: `tern_cam`

## Requirements
- R1: After reset every word reads as zero and is invalid, rdData is zero, matchVec is zero and miss is 1.
- R2: A write stores wrData at addr and marks that word valid. A read with rdEn shows the word at addr on rdData one cycle later, and rdData holds its value until the next accepted read.
- R3: An accepted search (srchEn high with wrEn and rdEn low) sets matchVec bit i one cycle later when word i is valid and equal to srchKey in every unmasked bit. Bit i of matchVec belongs to word address i.
- R4: A 1 in bit j of srchMask makes key bit j a don't-care, and a 0 in bit j makes that bit count in the comparison.
- R5: In the same cycle as matchVec, miss is 1 exactly when no bit of matchVec is set.
- R6: A word that has never been written does not match, even when the mask is all ones.
- R7: matchVec and miss keep their values until the next accepted search.
- R8: When srchEn is high together with wrEn or rdEn, the search is ignored and matchVec and miss are unchanged. The write or read still takes place.
- R9: Several words may match one key, and every matching word's flag is set.
- R10: A read and a write to the same address in one cycle return the word's previous contents on rdData, and the new data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Word address for read and write |
| wrData | input | 4 | Data to store |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 4 | Registered read result |
| srchEn | input | 1 | Search request |
| srchKey | input | 4 | Search key |
| srchMask | input | 4 | Per-bit don't-care, 1 = ignore the bit |
| matchVec | output | 4 | Registered per-word match flags |
| miss | output | 1 | Registered, high when no word matched |

## Verification
A corrupted stored bit or valid flag stays hidden until an access reaches it. It then shows as a wrong rdData one cycle after a read of that word, or as a wrong matchVec bit one cycle after any search whose unmasked bits cover the damaged position. For this reason the bench mixes exact and partly masked keys, and it searches with a fully masked key to expose the valid flags directly. A search accepted when it should have been blocked shows at once as a matchVec change in the following cycle, and that change stays visible until the next search.

// File: rtl/tern_cam_pkg.sv
package tern_cam_pkg;

  // Strobes from control to datapath, at most one of doSearch vs access
  typedef struct packed {
    logic doWrite;
    logic doRead;
    logic doSearch;
  } camStrobe_t;

endpackage

// File: rtl/tern_cam_ctrl.sv
module tern_cam_ctrl
  import tern_cam_pkg::*;
(
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       srchEn,
  output camStrobe_t strobe
);

  logic accessReq;

  // Any access claims the cycle; a search only runs in a free cycle
  always_comb begin
    accessReq       = wrEn | rdEn;
    strobe.doWrite  = wrEn;
    strobe.doRead   = rdEn;
    strobe.doSearch = srchEn & ~accessReq;
  end

endmodule

// File: rtl/tern_cam_store.sv
module tern_cam_store
  import tern_cam_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WIDTH  = 4,
  parameter int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  camStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [WIDTH-1:0]  srchKey,
  input  logic [WIDTH-1:0]  srchMask,
  output logic [WIDTH-1:0]  rdData,
  output logic [WORDS-1:0]  matchVec,
  output logic              miss,
  output logic [WORDS-1:0]  wordValid
);

  logic [WIDTH-1:0] cells [WORDS];
  logic [WORDS-1:0] wordSel;
  logic [WORDS-1:0] hitNow;
  logic [WIDTH-1:0] rdWord;

  // Address decoder: one select line per word
  for (genvar gi = 0; gi < WORDS; gi++) begin : g_dec
    assign wordSel[gi] = (addr == ADDR_W'(gi));
  end

  // Per-word ternary compare
  for (genvar gi = 0; gi < WORDS; gi++) begin : g_cmp
    logic [WIDTH-1:0] diffBits;
    assign diffBits   = (cells[gi] ^ srchKey) & ~srchMask;
    assign hitNow[gi] = wordValid[gi] & ~(|diffBits);
  end

  // Storage and valid flags
  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++) begin
      if (!rstN) begin
        cells[i]     <= '0;
        wordValid[i] <= 1'b0;
      end else if (strobe.doWrite && wordSel[i]) begin
        cells[i]     <= wrData;
        wordValid[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (wordSel[i]) rdWord = cells[i];
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.doRead) rdData <= rdWord;
  end

  // Registered search results, held between searches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchVec <= '0;
      miss     <= 1'b1;
    end else if (strobe.doSearch) begin
      matchVec <= hitNow;
      miss     <= ~(|hitNow);
    end
  end

endmodule

// File: rtl/tern_cam.sv
module tern_cam
  import tern_cam_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int WIDTH  = 4,
  parameter int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [WIDTH-1:0]  rdData,
  input  logic              srchEn,
  input  logic [WIDTH-1:0]  srchKey,
  input  logic [WIDTH-1:0]  srchMask,
  output logic [WORDS-1:0]  matchVec,
  output logic              miss
);

  camStrobe_t       strobe;
  logic [WORDS-1:0] wordValid;

  tern_cam_ctrl u_ctrl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .srchEn (srchEn),
    .strobe (strobe)
  );

  tern_cam_store #(
    .WORDS  (WORDS),
    .WIDTH  (WIDTH),
    .ADDR_W (ADDR_W)
  ) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addr      (addr),
    .wrData    (wrData),
    .srchKey   (srchKey),
    .srchMask  (srchMask),
    .rdData    (rdData),
    .matchVec  (matchVec),
    .miss      (miss),
    .wordValid (wordValid)
  );

endmodule

// File: rtl/tern_cam_check.sv
module tern_cam_check #(
  parameter int WORDS = 4
)(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic             srchEn,
  input logic [WORDS-1:0] matchVec,
  input logic             miss,
  input logic [WORDS-1:0] wordValid
);

  AST_MISS_IS_NOR: assert property (@(posedge clk) disable iff (!rstN)
    miss == (matchVec == '0)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !srchEn |=> ($stable(matchVec) && $stable(miss))); // R7

  AST_ACCESS_BLOCKS_SEARCH: assert property (@(posedge clk) disable iff (!rstN)
    (srchEn && (wrEn || rdEn)) |=> ($stable(matchVec) && $stable(miss))); // R8

  AST_INVALID_NO_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (matchVec & ~wordValid) == '0); // R6

endmodule

bind tern_cam tern_cam_check #(.WORDS(WORDS)) u_check (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .srchEn    (srchEn),
  .matchVec  (matchVec),
  .miss      (miss),
  .wordValid (wordValid)
);

// File: tb/tern_cam_bench.sv
module tern_cam_bench;

  localparam int WORDS = 4;
  localparam int WIDTH = 4;
  localparam int AW    = 2;

  logic             clk = 1'b0;
  logic             rstN;
  logic [AW-1:0]    addr;
  logic [WIDTH-1:0] wrData;
  logic             wrEn, rdEn, srchEn;
  logic [WIDTH-1:0] srchKey, srchMask;
  logic [WIDTH-1:0] rdData;
  logic [WORDS-1:0] matchVec;
  logic             miss;

  int  vecCount = 0;
  int  badCount = 0;
  bit  finished = 0;

  logic [WIDTH-1:0] refCell [WORDS];
  logic [WORDS-1:0] refValid;
  logic [WORDS-1:0] lastMatch;

  always #2 clk = ~clk;

  tern_cam u_tern_cam (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData), .srchEn(srchEn),
    .srchKey(srchKey), .srchMask(srchMask), .matchVec(matchVec), .miss(miss)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vecCount++;
    if (!ok) begin
      badCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WORDS-1:0] refHits(input logic [WIDTH-1:0] k,
                                               input logic [WIDTH-1:0] m);
    logic [WORDS-1:0] h;
    for (int i = 0; i < WORDS; i++)
      h[i] = refValid[i] && (((refCell[i] ^ k) & ~m) == '0);
    return h;
  endfunction

  // Drive one cycle of stimulus at a falling edge, release after the rising edge
  task automatic cycle(input logic w, input logic r, input logic s,
                       input logic [AW-1:0] a, input logic [WIDTH-1:0] d,
                       input logic [WIDTH-1:0] k, input logic [WIDTH-1:0] m);
    @(negedge clk);
    wrEn = w; rdEn = r; srchEn = s; addr = a; wrData = d; srchKey = k; srchMask = m;
    @(posedge clk);
    #1;
    wrEn = 0; rdEn = 0; srchEn = 0;
    @(negedge clk);
  endtask

  task automatic writeWord(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    cycle(1, 0, 0, a, d, '0, '0);
    refCell[a] = d; refValid[a] = 1'b1;
  endtask

  task automatic readWord(input logic [AW-1:0] a);
    cycle(0, 1, 0, a, '0, '0, '0);
    check(rdData == refCell[a], "R2 read", rdData, refCell[a]);
  endtask

  task automatic searchKey(input logic [WIDTH-1:0] k, input logic [WIDTH-1:0] m,
                           input string tag);
    logic [WORDS-1:0] e;
    e = refHits(k, m);
    cycle(0, 0, 1, '0, '0, k, m);
    check(matchVec == e, tag, matchVec, e);
    check(miss == (e == '0), "R5 miss", miss, (e == '0));
    lastMatch = e;
  endtask

  task automatic testReset();
    check(rdData == '0, "R1 rdData", rdData, 0);
    check(matchVec == '0, "R1 matchVec", matchVec, 0);
    check(miss == 1'b1, "R1 miss", miss, 1);
    readWord(2'd1);
    searchKey(4'h0, 4'hF, "R6 all invalid full mask");
  endtask

  task automatic testWriteRead();
    writeWord(2'd0, 4'h5);
    writeWord(2'd1, 4'h9);
    writeWord(2'd2, 4'h5);
    for (int i = 0; i < 3; i++) readWord(AW'(i));
    readWord(2'd3); // R1 untouched word stays zero
  endtask

  task automatic testSearches();
    searchKey(4'h0, 4'hF, "R6 unwritten word3 excluded");
    searchKey(4'h5, 4'h0, "R9 two exact hits");
    searchKey(4'h9, 4'h0, "R3 single exact hit");
    searchKey(4'h7, 4'h0, "R5 no hit");
    searchKey(4'h1, 4'hC, "R4 upper bits masked");
    searchKey(4'hD, 4'h4, "R4 bit2 masked");
  endtask

  task automatic testHold();
    searchKey(4'h9, 4'h0, "R3 setup");
    repeat (3) @(negedge clk);
    check(matchVec == lastMatch, "R7 hold idle", matchVec, lastMatch);
    readWord(2'd0);
    check(matchVec == lastMatch, "R7 hold over read", matchVec, lastMatch);
  endtask

  task automatic testConflict();
    cycle(1, 0, 1, 2'd3, 4'h7, 4'h7, 4'h0);
    refCell[3] = 4'h7; refValid[3] = 1'b1;
    check(matchVec == lastMatch, "R8 write beats search", matchVec, lastMatch);
    check(miss == (lastMatch == '0), "R8 miss held", miss, (lastMatch == '0));
    readWord(2'd3);
    cycle(0, 1, 1, 2'd2, '0, 4'h5, 4'h0);
    check(matchVec == lastMatch, "R8 read beats search", matchVec, lastMatch);
    check(rdData == refCell[2], "R8 read done", rdData, refCell[2]);
    searchKey(4'h7, 4'h0, "R3 newly written word hits");
  endtask

  task automatic testSameAddr();
    logic [WIDTH-1:0] old;
    old = refCell[1];
    cycle(1, 1, 0, 2'd1, 4'hE, '0, '0);
    check(rdData == old, "R10 old data on read", rdData, old);
    refCell[1] = 4'hE;
    readWord(2'd1);
    searchKey(4'hE, 4'h0, "R10 new data stored");
  endtask

  initial begin
    #100000;
    if (!finished) begin
      badCount++;
      vecCount++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrEn = 0; rdEn = 0; srchEn = 0;
    addr = '0; wrData = '0; srchKey = '0; srchMask = '0;
    refValid = '0; lastMatch = '0;
    for (int i = 0; i < WORDS; i++) refCell[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testWriteRead();
    testSearches();
    testHold();
    testConflict();
    testSameAddr();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, badCount);
    $finish;
  end

endmodule